// File: doc/BRIEF.md
# Fractional-N Pulse-Removal Divider

This block divides a stream of high-rate input pulses so that the long-run ratio between input pulses and output strobes is N + F/2^FW. N is the integer part and F is an unsigned fraction word. It runs in the input pulse's own clock domain. An input pulse is a cycle in which `pulse_in` is high. Every output period has either N or N+1 input pulses, and a first-order phase accumulator chooses between the two.

The divide-by-N counter never changes its preset. When a period must last N+1 pulses, the block removes exactly one input pulse ahead of the counter. This is done by holding the counter's synchronous count enable low for that single input cycle, so no clock is ever gated. The accumulator adds F once at the end of each output period. A carry out of the add marks the next period as a stealing period, and the first input pulse of that period is the one removed. The phase detector, loop filter and any higher-order noise shaping sit outside this block.

Top module: `fracn_divider`

## Requirements
- R1: During synchronous reset (`rst` high) `div_out` and `steal_flag` are 0. The accumulator is cleared, so the first output period after reset lasts exactly N input pulses.
- R2: Every output period spans either N or N+1 input pulses. Only cycles with `pulse_in` high count, and idle cycles in between change nothing. A period runs from the pulse after the previous period's terminal pulse up to and including its own terminal pulse.
- R3: For k ≥ 1, period k+1 lasts N+1 pulses if and only if adding `frac_word` to the FW-bit accumulator at the end of period k carries out of bit FW-1. Otherwise it lasts N pulses.
- R4: With `frac_word` = 0, no pulse is ever removed and every period is exactly N pulses.
- R5: With `frac_word` = 2^(FW-1) (one half), periods 1 and 2 last N pulses. From period 3 on, the periods alternate: odd-numbered periods last N+1 and even-numbered periods last N.
- R6: The input pulses counted from the end of period 1 to the end of period 2^FW+1 total exactly N·2^FW + `frac_word`.
- R7: With `frac_word` < 2^(FW-1), no two consecutive periods both contain a removed pulse.
- R8: `div_out` is high for exactly one cycle per period, namely the cycle after the period's terminal input pulse. It is never high on two consecutive cycles.
- R9: `steal_flag` is high for one cycle, the cycle after a removed input pulse. A stealing period contains exactly one such cycle and any other period contains none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | High for one input pulse in this cycle |
| n_int | input | NW | Integer ratio N, at least 2 |
| frac_word | input | FW | Fraction F scaled by 2^FW |
| div_out | output | 1 | One-cycle strobe per divided period |
| steal_flag | output | 1 | One-cycle flag after a removed input pulse |

## Verification
The assertions assume that `n_int` is at least 2 and that `n_int` and `frac_word` change only while `rst` is high. The counter bound and the spacing between strobes rely on that. The stimulus therefore draws N from 2 to 7 and a random fraction, loads both under reset, and holds them for the whole run. Pulse patterns are either a pulse in every cycle or random idle gaps. The one-half and zero fractions are exercised directly. A full 2^FW-period run with the minimum N checks the exact pulse total.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    // Register state of the pulse-removal gate
    typedef struct packed {
        logic pending;   // next input pulse must be removed
        logic steal;     // a pulse was removed last cycle
    } gate_state_t;

    localparam logic GATE_IDLE = 1'b0;

endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [FW-1:0] frac,
    output logic          carry
);
    localparam int SW = FW + 1;

    typedef struct packed {
        logic [FW-1:0] acc;
    } acc_state_t;

    acc_state_t    st_d, st_q;
    logic [SW-1:0] sum;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + {1'b0, frac};
        carry = sum[FW];
        if (step) begin
            st_d.acc = sum[FW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fracn_gate.sv
module fracn_gate
    import fracn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    input  logic term,
    input  logic carry,
    output logic cnt_en,
    output logic steal
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        cnt_en     = pulse_in && !st_q.pending;
        st_d.steal = pulse_in && st_q.pending;
        if (term) begin
            st_d.pending = carry;
        end else if (pulse_in) begin
            st_d.pending = GATE_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pending <= GATE_IDLE;
            st_q.steal   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign steal = st_q.steal;

    // R9: a removal flag always follows an input pulse
    a_r9_steal_after_pulse: assert property (@(posedge clk) disable iff (rst)
        st_q.steal |-> $past(pulse_in));

    // R3: a carry at the period end arms removal for the next period
    a_r3_carry_arms: assert property (@(posedge clk) disable iff (rst)
        (term && carry) |=> st_q.pending);

    // R7: an armed removal is consumed by the very next input pulse
    a_r7_pending_consumed: assert property (@(posedge clk) disable iff (rst)
        (st_q.pending && pulse_in) |=> !st_q.pending);

endmodule

// File: rtl/fracn_modn_counter.sv
module fracn_modn_counter #(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [NW-1:0] n_int,
    output logic          term,
    output logic          tick
);
    typedef struct packed {
        logic [NW-1:0] cnt;
        logic          tick;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_zero;

    always_comb begin
        st_d      = st_q;
        at_zero   = (st_q.cnt == '0);
        term      = en && at_zero;
        st_d.tick = term;
        if (en) begin
            st_d.cnt = at_zero ? (n_int - NW'(1)) : (st_q.cnt - NW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= n_int - NW'(1);
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    // R8: strobe never lasts two cycles (N >= 2)
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        st_q.tick |=> !st_q.tick);

    // R2: count state stays inside the divide-by-N range
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < n_int);

endmodule

// File: rtl/fracn_divider.sv
module fracn_divider #(
    parameter int NW = 8,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_in,
    input  logic [NW-1:0] n_int,
    input  logic [FW-1:0] frac_word,
    output logic          div_out,
    output logic          steal_flag
);
    logic cnt_en;
    logic term;
    logic carry;

    fracn_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .term     (term),
        .carry    (carry),
        .cnt_en   (cnt_en),
        .steal    (steal_flag)
    );

    fracn_modn_counter #(.NW(NW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .n_int (n_int),
        .term  (term),
        .tick  (div_out)
    );

    fracn_accum #(.FW(FW)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (term),
        .frac  (frac_word),
        .carry (carry)
    );

    // R9: a removal and a period end never share a cycle
    a_r9_no_steal_at_strobe: assert property (@(posedge clk) disable iff (rst)
        !(steal_flag && div_out));

endmodule

// File: tb/fracn_divider_bench.sv
module fracn_divider_bench;
    localparam int NW    = 8;
    localparam int FW    = 16;
    localparam int HALF  = 1 << (FW - 1);
    localparam int LIMIT = 195000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pulse_in = 1'b0;
    logic [NW-1:0] n_int = NW'(2);
    logic [FW-1:0] frac_word = '0;
    logic          div_out;
    logic          steal_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fracn_divider #(.NW(NW), .FW(FW)) u_fracn_divider (
        .clk        (clk),
        .rst        (rst),
        .pulse_in   (pulse_in),
        .n_int      (n_int),
        .frac_word  (frac_word),
        .div_out    (div_out),
        .steal_flag (steal_flag)
    );

    function automatic int exp_len(input int n, input bit stolen);
        return n + (stolen ? 1 : 0);
    endfunction

    function automatic bit acc_carry(input int acc, input int f);
        return ((acc + f) >> FW) != 0;
    endfunction

    function automatic int acc_next(input int acc, input int f);
        return (acc + f) & ((1 << FW) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input int n, input int f, input bit gaps,
                            input int periods, input bit each, input string tag);
        longint cnt = 0;
        longint last_mark = 0;
        longint first_mark = 0;
        int     seen = 0;
        int     acc = 0;
        bit     exp_steal = 1'b0;
        int     steals = 0;
        bit     prev_stole = 1'b0;
        int     consec = 0;
        bit     prev_div = 1'b0;
        int     double_div = 0;
        bit     p;
        rst = 1'b1;
        pulse_in = 1'b0;
        n_int = NW'(n);
        frac_word = FW'(f);
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(div_out == 1'b0 && steal_flag == 1'b0, "R1", "outputs in reset",
              {div_out, steal_flag}, 0);
        rst = 1'b0;
        while (seen < periods) begin
            @(negedge clk);
            if (cyc > LIMIT) begin
                timed_out = 1'b1;
                break;
            end
            if (steal_flag) steals++;
            if (div_out && prev_div) double_div++;
            prev_div = div_out;
            if (div_out) begin
                seen++;
                if (each) begin
                    check(cnt - last_mark == exp_len(n, exp_steal),
                          (seen == 1) ? "R1" : tag, "period length",
                          cnt - last_mark, exp_len(n, exp_steal));
                    // R9: one flag in a stealing period, none otherwise
                    check(steals == int'(exp_steal), "R9", "steal flags in period",
                          steals, int'(exp_steal));
                    if (tag == "R5") begin
                        check(steals == int'(seen >= 3 && (seen % 2) == 1), "R5",
                              "half-fraction alternation", steals,
                              int'(seen >= 3 && (seen % 2) == 1));
                    end
                end
                if (steals != 0 && prev_stole) consec++;
                prev_stole = (steals != 0);
                if (seen == 1) first_mark = cnt;
                last_mark = cnt;
                exp_steal = acc_carry(acc, f);
                acc = acc_next(acc, f);
                steals = 0;
            end
            p = gaps ? (($urandom % 3) != 0) : 1'b1;
            pulse_in = p;
            if (p) cnt++;
        end
        pulse_in = 1'b0;
        if (timed_out) return;
        // R8: never two strobe cycles back to back
        check(double_div == 0, "R8", "back-to-back strobes", double_div, 0);
        if (f < HALF) begin
            check(consec == 0, "R7", "consecutive removals", consec, 0);
        end
        if (periods == (1 << FW) + 1) begin
            check(last_mark - first_mark == longint'(n) * (1 << FW) + f, "R6",
                  "pulse total", last_mark - first_mark,
                  longint'(n) * (1 << FW) + f);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_case(5, 0, 1'b1, 30, 1'b1, "R4");
        if (!timed_out) run_case(5, HALF, 1'b0, 30, 1'b1, "R5");
        if (!timed_out) run_case(4, 13107, 1'b1, 40, 1'b1, "R3");
        if (!timed_out) run_case(3, 6554, 1'b0, 40, 1'b1, "R3");
        for (int i = 0; i < 3 && !timed_out; i++) begin
            run_case(2 + int'($urandom % 6), int'($urandom % (1 << FW)),
                     1'b1, 150, 1'b1, "R2");
        end
        if (!timed_out) begin
            run_case(2, int'($urandom % HALF), 1'b0, (1 << FW) + 1, 1'b0, "R6");
        end
        if (timed_out) begin
            check(1'b0, "watchdog", "cycles", cyc, LIMIT);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule